// File: doc/BRIEF.md
# Predicated Saturating Vector Absolute / Negate Unit

This unit takes a 128-bit source vector and, in every lane, forms either the saturating absolute value or the saturating negation of the lane. Lanes are 8, 16 or 32 bits wide. Each result is clamped to the signed range of its lane. The most negative lane value therefore becomes the signed maximum and counts as a saturation event. All other values are converted exactly.

A 16-bit predicate holds one bit per byte of the vector. Only the result bytes whose predicate bit is 1 replace bytes of the old destination vector. Every other byte passes the old destination through unchanged. The merged vector is produced combinationally from the inputs.

A lane whose lowest byte is enabled and which saturated sets a sticky saturation flag. This update happens at a clock edge where `issue` is high. The operation itself can never lower the flag. Only reset or the software clear input lowers it. Two instruction fields select the operation and the lane size, and illegal codes make the unit do nothing.

Top module: `vsat_unary_unit`

## Requirements
- R1: `size_fld` 00 selects 8-bit lanes (16 lanes), 01 selects 16-bit lanes (8 lanes) and 10 selects 32-bit lanes (4 lanes). Lane i occupies bits [i*W +: W] of the vectors.
- R2: `op_fld` 01 selects saturating absolute value. A non-negative lane is passed through, a negative lane is negated, and the most negative value gives the signed maximum and saturates.
- R3: `op_fld` 11 selects saturating negation. Every lane becomes -x exactly, except the most negative value, which gives the signed maximum and saturates.
- R4: `op_fld` 00 or 10 is illegal. No destination byte is written (`dst_vec` equals `old_dst`), `decode_ok` is 0 and the flag is unchanged.
- R5: `size_fld` 11 is reserved. No destination byte is written, `decode_ok` is 0 and the flag is unchanged.
- R6: For a legal operation, byte b of `dst_vec` is the result byte when `pred_mask[b]` is 1. Otherwise it is byte b of `old_dst`.
- R7: A lane contributes to the flag only when it saturated and the mask bit of its lowest byte, `pred_mask[i*bytes]`, is 1. With `issue` high, a contribution sets `qc_flag` on the next rising clock edge.
- R8: `qc_flag` is sticky. An operation never clears it. `qc_clr` clears it on the next edge and takes priority over a set in the same cycle.
- R9: Synchronous active-high `rst` forces `qc_flag` to 0.
- R10: With `issue` low, `qc_flag` holds its value whatever the other data inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| qc_clr | input | 1 | Synchronous clear of the saturation flag |
| issue | input | 1 | Marks the presented operation as executed this cycle |
| op_fld | input | 2 | Operation field: 01 absolute, 11 negate |
| size_fld | input | 2 | Lane size field: 00 byte, 01 half, 10 word, 11 reserved |
| src_vec | input | 128 | Source vector |
| old_dst | input | 128 | Prior destination vector |
| pred_mask | input | 16 | Per-byte write predicate |
| dst_vec | output | 128 | Merged destination vector |
| decode_ok | output | 1 | Fields decode to a legal operation |
| qc_flag | output | 1 | Sticky saturation flag |

## Verification
Embedded assertions check several properties on every cycle. Illegal and reserved encodings must leave the destination untouched. Unpredicated bytes must always carry the old destination. The flag must stay set across operations, must fall after a clear, must hold while `issue` is low, and must stay low when nothing contributes. The numeric results are shown only by the directed scenarios, which compare against an independent model. These cover the signed minimum, zero, the signed maximum and random values, for every lane width and both operations. The scenarios also cover the rule that only a lane's lowest byte gates the flag, and the priority of clear over set.

// File: rtl/vsat_pkg.sv
package vsat_pkg;

    localparam int VEC_BYTES_DEF = 16;
    localparam int NUM_SIZES     = 3;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_RSVD = 2'b11
    } size_e;

    localparam logic [1:0] OPC_ABS = 2'b01;
    localparam logic [1:0] OPC_NEG = 2'b11;

    typedef struct packed {
        logic  legal;
        logic  negate;
        size_e size;
    } dec_t;

    function automatic dec_t decode_fields(input logic [1:0] opc, input logic [1:0] szc);
        dec_t d;
        d.size   = size_e'(szc);
        d.negate = (opc == OPC_NEG);
        d.legal  = ((opc == OPC_ABS) || (opc == OPC_NEG)) && (d.size != SZ_RSVD);
        return d;
    endfunction

endpackage

// File: rtl/vsat_decode.sv
module vsat_decode
    import vsat_pkg::*;
(
    input  logic [1:0] op_fld,
    input  logic [1:0] size_fld,
    output dec_t       dec
);
    always_comb begin
        dec = decode_fields(op_fld, size_fld);
    end
endmodule

// File: rtl/vsat_lane.sv
module vsat_lane #(
    parameter int W = 8
) (
    input  logic [W-1:0] x,
    input  logic         negate,
    output logic [W-1:0] y,
    output logic         sat
);
    localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] MAXV = ~MINV;

    logic [W-1:0] neg_x;
    logic         is_min;

    always_comb begin
        neg_x  = '0 - x;
        is_min = (x == MINV);
        sat    = is_min;
        if (is_min)
            y = MAXV;
        else if (negate || x[W-1])
            y = neg_x;
        else
            y = x;
    end
endmodule

// File: rtl/vsat_lane_array.sv
module vsat_lane_array #(
    parameter int VB = 16,
    parameter int EB = 1
) (
    input  logic [VB*8-1:0] src,
    input  logic [VB-1:0]   mask,
    input  logic            negate,
    output logic [VB*8-1:0] res,
    output logic            hit
);
    localparam int W     = EB * 8;
    localparam int LANES = VB / EB;

    logic [LANES-1:0] lane_sat;
    logic [LANES-1:0] lane_hit;

    for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
        vsat_lane #(.W(W)) lane_i (
            .x      (src[ln*W +: W]),
            .negate (negate),
            .y      (res[ln*W +: W]),
            .sat    (lane_sat[ln])
        );
        assign lane_hit[ln] = lane_sat[ln] & mask[ln*EB];
    end

    assign hit = |lane_hit;
endmodule

// File: rtl/vsat_merge.sv
module vsat_merge #(
    parameter int VB = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [VB*8-1:0] res,
    input  logic [VB*8-1:0] old,
    input  logic [VB-1:0]   mask,
    input  logic            en,
    output logic [VB*8-1:0] dst
);
    for (genvar b = 0; b < VB; b++) begin : g_byte
        logic we;
        assign we = en & mask[b];
        assign dst[b*8 +: 8] = we ? res[b*8 +: 8] : old[b*8 +: 8];

        AST_MASK_KEEP: assert property (@(posedge clk) disable iff (rst)
            !mask[b] |-> (dst[b*8 +: 8] == old[b*8 +: 8])) // R6
            else $error("unpredicated byte altered");
    end
endmodule

// File: rtl/vsat_unary_unit.sv
module vsat_unary_unit
    import vsat_pkg::*;
#(
    parameter int VEC_BYTES = VEC_BYTES_DEF
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   qc_clr,
    input  logic                   issue,
    input  logic [1:0]             op_fld,
    input  logic [1:0]             size_fld,
    input  logic [VEC_BYTES*8-1:0] src_vec,
    input  logic [VEC_BYTES*8-1:0] old_dst,
    input  logic [VEC_BYTES-1:0]   pred_mask,
    output logic [VEC_BYTES*8-1:0] dst_vec,
    output logic                   decode_ok,
    output logic                   qc_flag
);
    localparam int VEC_BITS = VEC_BYTES * 8;

    dec_t                dec;
    logic [VEC_BITS-1:0] res_all [NUM_SIZES];
    logic [NUM_SIZES-1:0] hit_all;
    logic [VEC_BITS-1:0] res_sel;
    logic                hit_sel;
    logic                qc_hit;

    vsat_decode dec_i (
        .op_fld   (op_fld),
        .size_fld (size_fld),
        .dec      (dec)
    );

    for (genvar g = 0; g < NUM_SIZES; g++) begin : g_size
        vsat_lane_array #(.VB(VEC_BYTES), .EB(1 << g)) arr_i (
            .src    (src_vec),
            .mask   (pred_mask),
            .negate (dec.negate),
            .res    (res_all[g]),
            .hit    (hit_all[g])
        );
    end

    always_comb begin
        unique case (dec.size)
            SZ_BYTE: begin res_sel = res_all[0]; hit_sel = hit_all[0]; end
            SZ_HALF: begin res_sel = res_all[1]; hit_sel = hit_all[1]; end
            SZ_WORD: begin res_sel = res_all[2]; hit_sel = hit_all[2]; end
            default: begin res_sel = old_dst;    hit_sel = 1'b0;       end
        endcase
    end

    assign decode_ok = dec.legal;
    assign qc_hit    = dec.legal & hit_sel;

    vsat_merge #(.VB(VEC_BYTES)) merge_i (
        .clk  (clk),
        .rst  (rst),
        .res  (res_sel),
        .old  (old_dst),
        .mask (pred_mask),
        .en   (dec.legal),
        .dst  (dst_vec)
    );

    always_ff @(posedge clk) begin
        if (rst)
            qc_flag <= 1'b0;
        else if (qc_clr)
            qc_flag <= 1'b0;
        else if (issue && qc_hit)
            qc_flag <= 1'b1;
    end

    AST_BAD_OP_KEEP: assert property (@(posedge clk) disable iff (rst)
        (op_fld != OPC_ABS && op_fld != OPC_NEG) |-> (dst_vec == old_dst && !qc_hit)) // R4
        else $error("illegal op wrote destination");
    AST_RSV_SIZE_KEEP: assert property (@(posedge clk) disable iff (rst)
        (size_fld == 2'b11) |-> (dst_vec == old_dst && !qc_hit)) // R5
        else $error("reserved size wrote destination");
    AST_QC_STICKY: assert property (@(posedge clk) disable iff (rst)
        (qc_flag && !qc_clr) |=> qc_flag) // R8
        else $error("flag dropped without clear");
    AST_QC_CLEAR: assert property (@(posedge clk) disable iff (rst)
        qc_clr |=> !qc_flag) // R8
        else $error("clear did not win");
    AST_QC_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!issue && !qc_clr) |=> $stable(qc_flag)) // R10
        else $error("flag moved while idle");
    AST_QC_NO_HIT: assert property (@(posedge clk) disable iff (rst)
        (!qc_flag && !qc_hit) |=> !qc_flag) // R7
        else $error("flag set without contributing lane");
    AST_RST_CLEAR: assert property (@(posedge clk)
        rst |=> !qc_flag) // R9
        else $error("reset did not clear flag");
endmodule

// File: tb/vsat_unary_unit_tb.sv
module vsat_unary_unit_tb_top;
    logic         clk = 1'b0;
    logic         rst, qc_clr, issue;
    logic [1:0]   op_fld, size_fld;
    logic [127:0] src_vec, old_dst, dst_vec;
    logic [15:0]  pred_mask;
    logic         decode_ok, qc_flag;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  exp_qc = 1'b0;
    bit  done = 1'b0;

    always #4 clk = ~clk;

    vsat_unary_unit dut_i (
        .clk(clk), .rst(rst), .qc_clr(qc_clr), .issue(issue),
        .op_fld(op_fld), .size_fld(size_fld), .src_vec(src_vec),
        .old_dst(old_dst), .pred_mask(pred_mask), .dst_vec(dst_vec),
        .decode_ok(decode_ok), .qc_flag(qc_flag)
    );

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // Independent model built from the requirements
    task automatic ref_model(input logic [127:0] s, input logic [127:0] o, input logic [15:0] m,
                             input logic [1:0] sz, input logic [1:0] op,
                             output logic [127:0] d, output bit h, output bit lg);
        d  = o;
        h  = 1'b0;
        lg = (op == 2'b01 || op == 2'b11) && sz != 2'b11;
        if (lg) begin
            int eb = 1 << sz;
            int w  = 8 * eb;
            for (int ln = 0; ln < 16 / eb; ln++) begin
                longint raw, v, r, maxv;
                bit sat;
                raw  = longint'((s >> (ln * w)) & ((128'd1 << w) - 1));
                v    = (raw >= (64'sd1 <<< (w - 1))) ? raw - (64'sd1 <<< w) : raw;
                r    = (op == 2'b01) ? ((v < 0) ? -v : v) : -v;
                maxv = (64'sd1 <<< (w - 1)) - 1;
                sat  = (r > maxv);
                if (sat) r = maxv;
                for (int b = 0; b < eb; b++)
                    if (m[ln * eb + b]) d[(ln * eb + b) * 8 +: 8] = 8'(r >>> (8 * b));
                if (sat && m[ln * eb]) h = 1'b1;
            end
        end
    endtask

    task automatic run_op(input logic [127:0] s, input logic [127:0] o, input logic [15:0] m,
                          input logic [1:0] sz, input logic [1:0] op, input bit iss, input string req);
        logic [127:0] ed;
        bit eh, elg;
        @(negedge clk);
        src_vec = s; old_dst = o; pred_mask = m; size_fld = sz; op_fld = op; issue = iss;
        #1;
        ref_model(s, o, m, sz, op, ed, eh, elg);
        chk(dst_vec === ed, {req, " dst"}, dst_vec, ed);
        chk(decode_ok === elg, {req, " decode_ok"}, 128'(decode_ok), 128'(elg));
        @(negedge clk);
        issue = 1'b0;
        if (iss && eh) exp_qc = 1'b1;
        chk(qc_flag === exp_qc, {req, " qc"}, 128'(qc_flag), 128'(exp_qc));
    endtask

    task automatic do_clear();
        @(negedge clk); qc_clr = 1'b1;
        @(negedge clk); qc_clr = 1'b0; exp_qc = 1'b0;
        chk(qc_flag === 1'b0, "R8 clear", 128'(qc_flag), 128'd0);
    endtask

    function automatic logic [127:0] fill(input int w, input int kind);
        logic [127:0] v = '0;
        for (int ln = 0; ln < 128 / w; ln++) begin
            logic [31:0] e;
            case ((kind + ln) % 5)
                0: e = 32'h1 << (w - 1);
                1: e = 32'h0;
                2: e = (32'h1 << (w - 1)) - 1;
                3: e = 32'hFFFF_FFFF;
                default: e = $urandom;
            endcase
            for (int b = 0; b < w; b++) v[ln * w + b] = e[b];
        end
        return v;
    endfunction

    task automatic t_reset();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0; exp_qc = 1'b0;
        chk(qc_flag === 1'b0, "R9 reset", 128'(qc_flag), 128'd0);
    endtask

    task automatic t_corners();   // R1 R2 R3: every width, both ops, full mask
        for (int sz = 0; sz < 3; sz++) begin
            run_op(fill(8 << sz, 0), {4{32'hA5A5_5A5A}}, 16'hFFFF, 2'(sz), 2'b01, 1'b1, "R2 abs corners R1");
            do_clear();
            run_op(fill(8 << sz, 2), {4{32'h1234_5678}}, 16'hFFFF, 2'(sz), 2'b11, 1'b1, "R3 neg corners R1");
            do_clear();
        end
    endtask

    task automatic t_random_masks();   // R6 R7
        for (int i = 0; i < 40; i++) begin
            logic [127:0] s = fill(8 << (i % 3), i);
            logic [127:0] o = {$urandom, $urandom, $urandom, $urandom};
            run_op(s, o, 16'($urandom), 2'(i % 3), (i % 2) ? 2'b11 : 2'b01, 1'b1, "R6 random mask");
            if (i % 4 == 3) do_clear();
        end
    endtask

    task automatic t_low_byte_gate();   // R7: halfword lane 0 = 0x8000, only upper byte enabled
        do_clear();
        run_op(128'h8000, 128'h0, 16'h0002, 2'b01, 2'b01, 1'b1, "R7 upper byte only");
        chk(qc_flag === 1'b0, "R7 no set", 128'(qc_flag), 128'd0);
        run_op(128'h8000, 128'h0, 16'h0001, 2'b01, 2'b11, 1'b1, "R7 lowest byte");
        chk(qc_flag === 1'b1, "R7 set", 128'(qc_flag), 128'd1);
    endtask

    task automatic t_sticky();   // R8: non-saturating op leaves flag set
        run_op(128'h01, 128'h0, 16'hFFFF, 2'b00, 2'b11, 1'b1, "R8 sticky");
        chk(qc_flag === 1'b1, "R8 held", 128'(qc_flag), 128'd1);
        @(negedge clk);
        src_vec = 128'h80; pred_mask = 16'hFFFF; size_fld = 2'b00; op_fld = 2'b01;
        issue = 1'b1; qc_clr = 1'b1;
        @(negedge clk); issue = 1'b0; qc_clr = 1'b0; exp_qc = 1'b0;
        chk(qc_flag === 1'b0, "R8 clear beats set", 128'(qc_flag), 128'd0);
    endtask

    task automatic t_illegal();   // R4 R5
        run_op({16{8'h80}}, {16{8'h3C}}, 16'hFFFF, 2'b00, 2'b00, 1'b1, "R4 op 00");
        run_op({16{8'h80}}, {16{8'h3C}}, 16'hFFFF, 2'b01, 2'b10, 1'b1, "R4 op 10");
        run_op({16{8'h80}}, {16{8'h3C}}, 16'hFFFF, 2'b11, 2'b01, 1'b1, "R5 size 11 abs");
        run_op({16{8'h80}}, {16{8'h3C}}, 16'hFFFF, 2'b11, 2'b11, 1'b1, "R5 size 11 neg");
    endtask

    task automatic t_no_issue();   // R10
        run_op({4{32'h8000_0000}}, 128'h0, 16'hFFFF, 2'b10, 2'b11, 1'b0, "R10 issue low");
        chk(qc_flag === 1'b0, "R10 flag", 128'(qc_flag), 128'd0);
    endtask

    initial begin
        rst = 1'b1; qc_clr = 1'b0; issue = 1'b0; op_fld = 2'b01; size_fld = 2'b00;
        src_vec = '0; old_dst = '0; pred_mask = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_corners();
        t_random_masks();
        t_low_byte_gate();
        t_sticky();
        t_illegal();
        t_no_issue();
        t_reset();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog act=timeout exp=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule